// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

The block is a byte-wide timer for a 4.194304 MHz system clock. A 16-bit free-running prescale counter runs on every clock. Its upper byte can be read as a divider value. An 8-bit count register steps on edges taken from taps of that prescale counter, at one of four rates. When the count register steps past 0xFF, it loads a programmable modulo byte instead of wrapping to zero. At the same time it raises a single-cycle interrupt request toward an external interrupt controller.

Software reaches four registers through a small port: a 2-bit address, an 8-bit write bus, and separate write and read strobes. A control register holds an enable bit and a 2-bit rate code. Rewriting the control register while a step is pending follows a simple, documented rule. It does not reproduce any glitch.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_o` is low.
- R2: Reads are combinational in the cycle `reg_rd_i` is high. Address 0 returns the divider (bits 15:8 of the prescale counter), address 1 the count register, address 2 the modulo byte, and address 3 the control value in bits 2:0 with bits 7:3 as zero. While `reg_rd_i` is low, `reg_rdata_o` is 0x00.
- R3: The prescale counter rises by one on every clock. A write to address 0, whatever the data, clears all 16 bits at that edge.
- R4: Control bit 2 is the run enable. While it is 0, the count register holds its value and the prescale counter keeps running.
- R5: Control bits 1:0 pick the step period in clocks: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256. With period P, a step happens at each edge where the prescale counter's value before the edge, taken modulo P, equals P-1, provided run is enabled.
- R6: A step from 0xFF loads the modulo byte as it stood before that edge, so a modulo write in the same cycle first applies to the next overflow.
- R7: An overflow drives `irq_o` high for exactly one clock, in the cycle after the overflow edge. In that cycle the count register already shows the reloaded value.
- R8: A write to address 1 in the same cycle as a step takes priority: the count register takes the written byte and no interrupt is raised.
- R9: A write to address 0 in the same cycle as a pending step cancels that step.
- R10: Writes to the modulo and control registers take effect from the edge at which they are written. The control rate and enable apply to steps from the following edge on.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Write data |
| reg_wr_i | input | 1 | Write strobe, one write per cycle high |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Read data, zero when not reading |
| irq_o | output | 1 | Single-cycle timer interrupt request |

## Verification
A wrong prescale phase shows up at the ports as a count register that steps at the wrong edge. It reaches a read of address 1 within one period, and `irq_o` lands on the wrong cycle at the next overflow. A wrong reload or priority decision is visible on the first read after the overflow edge and on the interrupt line in that same cycle. The bench therefore steers writes onto the exact edge of a pending step or overflow. It compares every cycle of `irq_o` against an independent cycle model.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DIV_W  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 3;
  localparam int RUN_BIT = 2;

  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIV  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_MOD  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // log2 of the step period for each rate code
  function automatic int rate_shift(input logic [1:0] code);
    case (code)
      2'b00:   return 10;
      2'b01:   return 4;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction

  // returns {wrapped, next value} for one step of the count register
  function automatic logic [DATA_W:0] count_step(input byte_t cur, input byte_t reload);
    if (cur == {DATA_W{1'b1}}) return {1'b1, reload};
    return {1'b0, cur + byte_t'(1)};
  endfunction
endpackage

// File: rtl/pit_divider.sv
module pit_divider #(
  parameter int WIDTH = pit_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [WIDTH-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_o <= '0;
    else if (clear_i) div_o <= '0;
    else              div_o <= div_o + 1'b1;
  end
endmodule

// File: rtl/pit_rate_tap.sv
module pit_rate_tap #(
  parameter int WIDTH = pit_pkg::DIV_W
) (
  input  logic [WIDTH-1:0] div_i,
  input  logic [1:0]       rate_i,
  input  logic             run_i,
  input  logic             clear_i,
  output logic             tick_o
);
  localparam int NRATES = 4;
  logic [NRATES-1:0] hit;

  for (genvar g = 0; g < NRATES; g++) begin : g_tap
    localparam int SH = pit_pkg::rate_shift(2'(g));
    assign hit[g] = &div_i[SH-1:0];
  end

  assign tick_o = run_i & ~clear_i & hit[rate_i];
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  load_i,
  input  byte_t load_val_i,
  input  byte_t modulo_i,
  output byte_t cnt_o,
  output logic  ovf_o,
  output logic  irq_o
);
  logic  wrapped;
  byte_t stepped;

  assign {wrapped, stepped} = count_step(cnt_o, modulo_i);
  assign ovf_o = tick_i & ~load_i & wrapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= ovf_o;
      if (load_i)      cnt_o <= load_val_i;
      else if (tick_i) cnt_o <= stepped;
    end
  end
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic              wr_div, wr_cnt, wr_mod, wr_ctrl;
  logic [DIV_W-1:0]  div_q;
  logic [CTRL_W-1:0] ctrl_q;
  byte_t             mod_q, cnt_q;
  logic              tick, ovf;

  assign wr_div  = reg_wr_i && (reg_addr_i == SEL_DIV);
  assign wr_cnt  = reg_wr_i && (reg_addr_i == SEL_CNT);
  assign wr_mod  = reg_wr_i && (reg_addr_i == SEL_MOD);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_mod)  mod_q  <= reg_wdata_i;
      if (wr_ctrl) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
    end
  end

  pit_divider #(.WIDTH(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (wr_div),
    .div_o   (div_q)
  );

  pit_rate_tap #(.WIDTH(DIV_W)) u_tap (
    .div_i   (div_q),
    .rate_i  (ctrl_q[1:0]),
    .run_i   (ctrl_q[RUN_BIT]),
    .clear_i (wr_div),
    .tick_o  (tick)
  );

  pit_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (wr_cnt),
    .load_val_i (reg_wdata_i),
    .modulo_i   (mod_q),
    .cnt_o      (cnt_q),
    .ovf_o      (ovf),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      case (reg_addr_i)
        SEL_DIV:  reg_rdata_o = div_q[DIV_W-1 -: DATA_W];
        SEL_CNT:  reg_rdata_o = cnt_q;
        SEL_MOD:  reg_rdata_o = mod_q;
        default:  reg_rdata_o = byte_t'(ctrl_q);
      endcase
    end
  end
endmodule

// File: rtl/pit_checker.sv
module pit_checker
  import pit_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_div,
  input logic             wr_cnt,
  input byte_t            wdata,
  input logic [DIV_W-1:0] div_q,
  input byte_t            cnt_q,
  input byte_t            mod_q,
  input logic             run,
  input logic             tick,
  input logic             irq
);
  assert_div_runs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_div |=> div_q == $past(div_q) + 1'b1);

  assert_div_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_div |=> div_q == '0);

  assert_hold_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_cnt) |=> $stable(cnt_q));

  assert_tick_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> div_q[3:0] == 4'd0);

  assert_step_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_cnt && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> cnt_q == $past(mod_q));

  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |=> !irq);

  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt_q == $past(wdata)) && !irq);

  assert_div_cancels_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_div && !wr_cnt) |=> $stable(cnt_q));
endmodule

bind prog_interval_timer pit_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_div (wr_div),
  .wr_cnt (wr_cnt),
  .wdata  (reg_wdata_i),
  .div_q  (div_q),
  .cnt_q  (cnt_q),
  .mod_q  (mod_q),
  .run    (ctrl_q[2]),
  .tick   (tick),
  .irq    (irq_o)
);

// File: tb/prog_interval_timer_tb.sv
module prog_interval_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_interval_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // independent cycle model built from the requirements
  logic [15:0] m_div;
  logic [7:0]  m_cnt, m_mod;
  logic [2:0]  m_ctrl;
  logic        m_irq;

  function automatic int period_of(input logic [1:0] c);
    case (c)
      2'd0: return 1024;
      2'd1: return 16;
      2'd2: return 64;
      default: return 256;
    endcase
  endfunction

  function automatic bit step_due(input logic [15:0] d, input logic [2:0] c, input bit divwr);
    int p = period_of(c[1:0]);
    return c[2] && !divwr && ((int'(d) % p) == p - 1);
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_div[15:8];
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return {5'd0, m_ctrl};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= '0; m_cnt <= '0; m_mod <= '0; m_ctrl <= '0; m_irq <= 1'b0;
    end else begin
      bit due;
      due = step_due(m_div, m_ctrl, wr && addr == 2'd0);
      m_div <= (wr && addr == 2'd0) ? 16'd0 : m_div + 16'd1;
      if (wr && addr == 2'd2) m_mod <= wdata;
      if (wr && addr == 2'd3) m_ctrl <= wdata[2:0];
      m_irq <= 1'b0;
      if (wr && addr == 2'd1) m_cnt <= wdata;
      else if (due) begin
        if (m_cnt == 8'hFF) begin m_cnt <= m_mod; m_irq <= 1'b1; end
        else m_cnt <= m_cnt + 8'd1;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // interrupt line compared every cycle it is active in either view
  always @(negedge clk) begin
    if (rst_n && (irq !== m_irq || m_irq)) check("R7 irq", {15'd0, irq}, {15'd0, m_irq});
  end

  // called just after a falling edge; occupies one cycle
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd = 1'b1;
    #1;
    check(tag, {8'd0, rdata}, {8'd0, exp});
    rd = 1'b0;
  endtask

  task automatic wait_due();
    while (!step_due(m_div, m_ctrl, 1'b0)) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) rd_reg(2'(a), 8'h00, "R1 reset read");
    check("R1 irq after reset", {15'd0, irq}, 16'd0);

    // R2: read strobe low returns zero
    @(negedge clk);
    wr_reg(2'd2, 8'h5A);
    addr = 2'd2; rd = 1'b0; #1;
    check("R2 idle rdata", {8'd0, rdata}, 16'd0);
    rd_reg(2'd2, 8'h5A, "R2 modulo read");
    wr_reg(2'd3, 8'hFB);
    rd_reg(2'd3, 8'h03, "R2 control upper bits zero");

    // R3: divider clear and run
    wr_reg(2'd0, 8'hC3);
    repeat (699) @(negedge clk);
    rd_reg(2'd0, 8'd2, "R3 divider after 700 clocks");

    // R4: stopped counter holds, divider keeps going
    wr_reg(2'd1, 8'h10);
    wr_reg(2'd3, 8'h01);
    repeat (200) @(negedge clk);
    rd_reg(2'd1, 8'h10, "R4 counter held");
    rd_reg(2'd0, model_read(2'd0), "R4 divider running");

    // R5: each rate code
    for (int c = 0; c < 4; c++) begin
      wr_reg(2'd1, 8'h00);
      wr_reg(2'd0, 8'h00);
      wr_reg(2'd3, 8'(4 + c));
      repeat (3 * period_of(2'(c)) + 5) @(negedge clk);
      rd_reg(2'd1, 8'd3, "R5 three steps at selected rate");
    end

    // R6/R7: overflow reload and pulse
    wr_reg(2'd3, 8'h05);
    wr_reg(2'd2, 8'hA0);
    wr_reg(2'd1, 8'hFE);
    while (!irq) @(negedge clk);
    rd_reg(2'd1, 8'hA0, "R7 counter reloaded during pulse");
    @(negedge clk);
    check("R7 pulse one clock", {15'd0, irq}, 16'd0);

    // R6: modulo written on the overflow edge applies next time
    wr_reg(2'd1, 8'hFF);
    wait_due();
    wr_reg(2'd2, 8'h33);
    rd_reg(2'd1, 8'hA0, "R6 old modulo used");
    wr_reg(2'd1, 8'hFF);
    while (!irq) @(negedge clk);
    rd_reg(2'd1, 8'h33, "R6 new modulo next overflow");

    // R8: counter write beats overflow
    @(negedge clk);
    wr_reg(2'd1, 8'hFF);
    wait_due();
    wr_reg(2'd1, 8'h55);
    check("R8 no irq on write edge", {15'd0, irq}, 16'd0);
    rd_reg(2'd1, 8'h55, "R8 written value kept");

    // R9: divider write cancels the pending step
    wr_reg(2'd1, 8'h60);
    wait_due();
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd1, 8'h60, "R9 step cancelled");

    // R10: control change applies to later steps
    wr_reg(2'd3, 8'h00);
    repeat (40) @(negedge clk);
    rd_reg(2'd1, 8'h60, "R10 disable applied");

    // constrained random phase against the model
    for (int i = 0; i < 5000; i++) begin
      int op = $urandom_range(0, 99);
      if (op < 3)       wr_reg(2'd0, 8'($urandom));
      else if (op < 8)  wr_reg(2'd1, 8'($urandom_range(200, 255)));
      else if (op < 11) wr_reg(2'd2, 8'($urandom_range(200, 255)));
      else if (op < 13) wr_reg(2'd3, 8'($urandom_range(4, 7)));
      else if (op < 25) begin
        logic [1:0] a = 2'($urandom_range(0, 3));
        rd_reg(a, model_read(a), "R2 random read vs model");
        @(negedge clk);
      end else @(negedge clk);
    end
    for (int a = 0; a < 4; a++) rd_reg(2'(a), model_read(2'(a)), "R5 final state vs model");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule